// File: doc/BRIEF.md
# Wormhole Flit Hop Link

This block carries flits across one hop between two neighbouring routers of a wormhole-switched network. Its sending half collects flits from a small set of local sources and its receiving half keeps exactly one flit until the next hop takes it. One shared pacing wire sets the rate of transfer. The receiver pulls the wire low while its buffer is empty. The sender drives it high for one clock to launch a flit, and the receiver's full buffer then keeps it high until that flit has moved on.

A packet is a header flit followed by body flits and closed by a tail flit, or it is a single self-contained flit. The top two bits of every flit give its kind. In a header, the remaining bits hold the destination and the sequence number, which this hop passes through unchanged. When a header from one source crosses the link, the sender grants the link to that source alone until the packet's closing flit has crossed, so flits of different packets never interleave. The receiver tracks open packets on its own side, and it drops and reports any continuation flit that arrives while no packet is open.

Top module: `flit_hop_link`

## Requirements
- R1: After reset the sender does not drive the pacing wire, the receiver buffer is empty so the wire reads 0, `out_valid` and `err_orphan` are 0, and no packet is open (a body or tail flit sent first is reported as an orphan).
- R2: A source flit is accepted (its `src_accept` bit high, at most one bit at a time) only in a cycle where the wire reads 0 and the sender is not driving. While the receiver holds a flit, no source is accepted.
- R3: The sender drives the wire high for exactly the one cycle after an accept. The wire then stays high until the receiver's buffer has been drained.
- R4: A held flit keeps `out_valid` high and `out_flit` stable until `out_taken` is seen. The buffer empties at that edge and the wire reads 0 in the following cycle.
- R5: Flit bits arrive unchanged and in source order. A flit accepted in cycle t is shown on `out_flit` with `out_valid` from cycle t+2.
- R6: Once a header flit (kind 2'b00, bits [FLIT_W-1:FLIT_W-2]) from source i has been accepted, only source i is accepted until its tail (2'b10) or single-flit (2'b11) has been accepted.
- R7: When no packet holds the link, the lowest-numbered source with a valid flit wins.
- R8: A body (2'b01) or tail (2'b10) flit that reaches the receiver while no packet is open raises `err_orphan` for one cycle and is dropped: it never appears on `out_valid`, and the wire returns low at once.
- R9: A single-flit packet (2'b11) opens no lock, so any source may win the next arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock of both link halves |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_valid | input | NSRC | Per-source flit available |
| src_flit | input | NSRC*FLIT_W | Source flits, source k in bits [k*FLIT_W +: FLIT_W] |
| src_accept | output | NSRC | One-hot pulse: the source's flit was taken this cycle |
| ra_line | output | 1 | Resolved level of the pacing wire |
| out_valid | output | 1 | Receiver buffer holds a flit |
| out_flit | output | FLIT_W | Flit held in the receiver buffer |
| out_taken | input | 1 | Next hop removes the held flit at this edge |
| err_orphan | output | 1 | One-cycle pulse: a continuation flit arrived outside any packet and was dropped |

## Verification
A sender whose lock state went wrong would show up within one arbitration slot, about three cycles: a flit from another source would appear in the middle of a packet on `out_flit`. A receiver whose open-packet state went wrong would either pulse `err_orphan` on a legal body flit or deliver an orphan, and the next continuation flit exposes either fault. A stuck strobe or a stuck buffer flag leaves `ra_line` high, after which `src_accept` never pulses again, so the stall is visible within a few cycles.

// File: rtl/flit_link_pkg.sv
package flit_link_pkg;

  typedef enum logic [1:0] {
    FK_HEAD = 2'b00,
    FK_BODY = 2'b01,
    FK_TAIL = 2'b10,
    FK_SOLO = 2'b11
  } flit_kind_e;

  function automatic logic kind_closes(input flit_kind_e k);
    return (k == FK_TAIL) || (k == FK_SOLO);
  endfunction

  function automatic logic kind_continues(input flit_kind_e k);
    return (k == FK_BODY) || (k == FK_TAIL);
  endfunction

endpackage

// File: rtl/link_grant.sv
module link_grant #(
  parameter int NSRC  = 2,
  parameter int IDX_W = 1
) (
  input  logic [NSRC-1:0]  req,
  input  logic             lock_open,
  input  logic [IDX_W-1:0] owner,
  output logic             gnt_vld,
  output logic [IDX_W-1:0] gnt_idx
);

  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    if (lock_open) begin
      gnt_vld = req[owner];
      gnt_idx = owner;
    end else begin
      for (int k = NSRC - 1; k >= 0; k--) begin
        if (req[k]) begin
          gnt_vld = 1'b1;
          gnt_idx = IDX_W'(k);
        end
      end
    end
  end

endmodule

// File: rtl/link_sender.sv
module link_sender
  import flit_link_pkg::*;
#(
  parameter int NSRC   = 2,
  parameter int FLIT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        src_valid,
  input  logic [NSRC*FLIT_W-1:0] src_flit,
  output logic [NSRC-1:0]        src_accept,
  input  logic                   line_in,
  output logic                   drive_high,
  output logic [FLIT_W-1:0]      chan_flit
);

  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [FLIT_W-1:0] lane [NSRC];
  logic              drive_q, drive_d;
  logic              lock_q, lock_d;
  logic [IDX_W-1:0]  owner_q, owner_d;
  logic [FLIT_W-1:0] flit_q, flit_d;
  logic              gnt_vld;
  logic [IDX_W-1:0]  gnt_idx;
  logic              launch;
  flit_kind_e        sel_kind;

  for (genvar g = 0; g < NSRC; g++) begin : g_lane
    assign lane[g]       = src_flit[g*FLIT_W +: FLIT_W];
    assign src_accept[g] = launch && (gnt_idx == IDX_W'(g));
  end

  link_grant #(.NSRC(NSRC), .IDX_W(IDX_W)) u_grant (
    .req       (src_valid),
    .lock_open (lock_q),
    .owner     (owner_q),
    .gnt_vld   (gnt_vld),
    .gnt_idx   (gnt_idx)
  );

  assign launch   = !drive_q && !line_in && gnt_vld;
  assign sel_kind = flit_kind_e'(lane[gnt_idx][FLIT_W-1 -: 2]);

  always_comb begin
    drive_d = drive_q;
    lock_d  = lock_q;
    owner_d = owner_q;
    flit_d  = flit_q;
    if (drive_q) begin
      drive_d = 1'b0;
    end else if (launch) begin
      drive_d = 1'b1;
      flit_d  = lane[gnt_idx];
      if (sel_kind == FK_HEAD) begin
        lock_d  = 1'b1;
        owner_d = gnt_idx;
      end else if (kind_closes(sel_kind)) begin
        lock_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      lock_q  <= 1'b0;
      owner_q <= '0;
    end else begin
      drive_q <= drive_d;
      lock_q  <= lock_d;
      owner_q <= owner_d;
    end
  end

  always_ff @(posedge clk) begin
    if (launch) flit_q <= flit_d;
  end

  assign drive_high = drive_q;
  assign chan_flit  = flit_q;

  // R3: the launch strobe lasts a single cycle
  a_r3_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q |=> !drive_q);

  // R2: a high wire seen while idle blocks the next launch
  a_r2_no_launch_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_q && line_in) |=> !drive_q);

  // R6: an open lock keeps its owner until a closing flit is launched
  a_r6_lock_holds_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !launch) |=> (lock_q && $stable(owner_q)));

endmodule

// File: rtl/link_receiver.sv
module link_receiver
  import flit_link_pkg::*;
#(
  parameter int FLIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic [FLIT_W-1:0] chan_flit,
  output logic              pull_low,
  output logic              out_valid,
  output logic [FLIT_W-1:0] out_flit,
  input  logic              out_taken,
  output logic              err_orphan
);

  logic              full_q, full_d;
  logic              open_q, open_d;
  logic              err_q, err_d;
  logic [FLIT_W-1:0] buf_q;
  logic              capture, orphan, keep;
  flit_kind_e        in_kind;

  assign in_kind = flit_kind_e'(chan_flit[FLIT_W-1 -: 2]);
  assign capture = line_in && !full_q;
  assign orphan  = capture && !open_q && kind_continues(in_kind);
  assign keep    = capture && !orphan;

  always_comb begin
    full_d = full_q;
    open_d = open_q;
    err_d  = orphan;
    if (full_q && out_taken) full_d = 1'b0;
    if (keep) begin
      full_d = 1'b1;
      if (in_kind == FK_HEAD)        open_d = 1'b1;
      else if (kind_closes(in_kind)) open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      open_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      open_q <= open_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (keep) buf_q <= chan_flit;
  end

  assign pull_low   = !full_q;
  assign out_valid  = full_q;
  assign out_flit   = buf_q;
  assign err_orphan = err_q;

  // R4: a held flit stays put until the next hop takes it
  a_r4_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !out_taken) |=> (full_q && $stable(buf_q)));

  // R8: a dropped orphan leaves the buffer empty
  a_r8_orphan_not_kept: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !full_q);

  // R4: a drained buffer releases the wire in the following cycle
  a_r4_release_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && out_taken) |=> pull_low);

endmodule

// File: rtl/flit_hop_link.sv
module flit_hop_link #(
  parameter int NSRC   = 2,
  parameter int FLIT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        src_valid,
  input  logic [NSRC*FLIT_W-1:0] src_flit,
  output logic [NSRC-1:0]        src_accept,
  output logic                   ra_line,
  output logic                   out_valid,
  output logic [FLIT_W-1:0]      out_flit,
  input  logic                   out_taken,
  output logic                   err_orphan
);

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic              drive_high;
  logic              pull_low;
  logic [FLIT_W-1:0] chan_flit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // open-drain resolution: the receiver holds the wire low only while empty,
  // and the sender's high drive overrides that pull
  assign ra_line = drive_high || !pull_low;

  link_sender #(.NSRC(NSRC), .FLIT_W(FLIT_W)) u_tx (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .src_valid  (src_valid),
    .src_flit   (src_flit),
    .src_accept (src_accept),
    .line_in    (ra_line),
    .drive_high (drive_high),
    .chan_flit  (chan_flit)
  );

  link_receiver #(.FLIT_W(FLIT_W)) u_rx (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .line_in    (ra_line),
    .chan_flit  (chan_flit),
    .pull_low   (pull_low),
    .out_valid  (out_valid),
    .out_flit   (out_flit),
    .out_taken  (out_taken),
    .err_orphan (err_orphan)
  );

  // R2: at most one source is taken per cycle
  a_r2_single_accept: assert property (@(posedge clk) disable iff (!core_rst_n)
    $onehot0(src_accept));

  // R5: an accepted flit reaches the buffer two edges later
  a_r5_arrival: assert property (@(posedge clk) disable iff (!core_rst_n)
    (|src_accept) |=> ##1 (out_valid || err_orphan));

endmodule

// File: tb/test_flit_hop_link.sv
module test_flit_hop_link;

  localparam int NSRC = 2;
  localparam int FW   = 16;

  logic             clk;
  logic             rst_n;
  logic [NSRC-1:0]  src_valid;
  logic [NSRC*FW-1:0] src_flit;
  logic [NSRC-1:0]  src_accept;
  logic             ra_line;
  logic             out_valid;
  logic [FW-1:0]    out_flit;
  logic             out_taken;
  logic             err_orphan;

  int checks;
  int fails;
  int cyc;

  logic [FW-1:0] fmem [NSRC][8];
  int            flen [NSRC];
  int            fidx [NSRC];
  logic          feed_on [NSRC];
  logic          acc_pend [NSRC];
  logic          sink_on;
  logic [FW-1:0] log_q [32];
  int            log_n;
  int            errs;

  flit_hop_link #(.NSRC(NSRC), .FLIT_W(FW)) i_flit_hop_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_valid  (src_valid),
    .src_flit   (src_flit),
    .src_accept (src_accept),
    .ra_line    (ra_line),
    .out_valid  (out_valid),
    .out_flit   (out_flit),
    .out_taken  (out_taken),
    .err_orphan (err_orphan)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // sources and sink: inputs change at the falling edge only
  always @(negedge clk) begin
    for (int i = 0; i < NSRC; i++)
      if (acc_pend[i]) fidx[i] = fidx[i] + 1;
    for (int i = 0; i < NSRC; i++) begin
      src_valid[i] = feed_on[i] && (fidx[i] < flen[i]);
      src_flit[i*FW +: FW] = (fidx[i] < 8) ? fmem[i][fidx[i]] : '0;
    end
    #1;
    for (int i = 0; i < NSRC; i++) acc_pend[i] = src_accept[i];
    if (out_valid && sink_on) begin
      if (log_n < 32) log_q[log_n] = out_flit;
      log_n = log_n + 1;
      out_taken = 1'b1;
    end else begin
      out_taken = 1'b0;
    end
    if (err_orphan) errs = errs + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic wait_cycles(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic do_reset();
    step();
    rst_n = 1'b0;
    for (int i = 0; i < NSRC; i++) feed_on[i] = 1'b0;
    sink_on = 1'b0;
    wait_cycles(2);
    for (int i = 0; i < NSRC; i++) begin
      fidx[i] = 0;
      flen[i] = 0;
      acc_pend[i] = 1'b0;
    end
    log_n = 0;
    errs = 0;
    rst_n = 1'b1;
    wait_cycles(4);
  endtask

  task automatic wait_taken(input int src, input int n);
    for (int k = 0; k < 20; k++) begin
      if (fidx[src] >= n) break;
      step();
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 wire low", 32'(ra_line), 32'd0);
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 err_orphan", 32'(err_orphan), 32'd0);
    chk("R1 no accept", 32'(src_accept), 32'd0);
  endtask

  task automatic t_timing();
    do_reset();
    fmem[0][0] = 16'hC0A5; flen[0] = 1; feed_on[0] = 1'b1;
    step();
    chk("R2 accept on low wire", 32'(src_accept), 32'h1);
    chk("R2 wire low at accept", 32'(ra_line), 32'd0);
    step();
    chk("R3 wire driven high", 32'(ra_line), 32'd1);
    chk("R5 not yet visible", 32'(out_valid), 32'd0);
    step();
    chk("R5 visible at t+2", 32'(out_valid), 32'd1);
    chk("R5 flit bits", 32'(out_flit), 32'hC0A5);
    chk("R3 wire high while held", 32'(ra_line), 32'd1);
    fmem[1][0] = 16'hC05A; flen[1] = 1; feed_on[1] = 1'b1;
    step();
    chk("R2 no accept while held", 32'(src_accept), 32'd0);
    step();
    chk("R4 still held", 32'(out_valid), 32'd1);
    chk("R4 flit stable", 32'(out_flit), 32'hC0A5);
    chk("R3 wire stays high", 32'(ra_line), 32'd1);
    sink_on = 1'b1;
    step();
    chk("R4 held in take cycle", 32'(out_valid), 32'd1);
    step();
    chk("R4 empty after take", 32'(out_valid), 32'd0);
    chk("R4 wire low after take", 32'(ra_line), 32'd0);
    chk("R2 second source accepted", 32'(src_accept), 32'h2);
    wait_cycles(6);
    chk("R5 two flits delivered", 32'(log_n), 32'd2);
    chk("R5 first flit", 32'(log_q[0]), 32'hC0A5);
    chk("R5 second flit", 32'(log_q[1]), 32'hC05A);
  endtask

  task automatic t_stream();
    logic [FW-1:0] pk [5];
    do_reset();
    pk[0] = 16'h0123; pk[1] = 16'h4111; pk[2] = 16'h4222; pk[3] = 16'h4333; pk[4] = 16'h8444;
    for (int i = 0; i < 5; i++) fmem[0][i] = pk[i];
    flen[0] = 5; sink_on = 1'b1; feed_on[0] = 1'b1;
    wait_cycles(40);
    chk("R5 stream count", 32'(log_n), 32'd5);
    for (int i = 0; i < 5; i++) chk("R5 stream order", 32'(log_q[i]), 32'(pk[i]));
    chk("R8 no error on legal packet", 32'(errs), 32'd0);
  endtask

  task automatic t_lock();
    do_reset();
    fmem[1][0] = 16'h0A01; fmem[1][1] = 16'h4A02; fmem[1][2] = 16'h8A03; flen[1] = 3;
    fmem[0][0] = 16'hC0B0; flen[0] = 1;
    sink_on = 1'b1; feed_on[1] = 1'b1;
    wait_taken(1, 1);
    feed_on[0] = 1'b1;
    wait_cycles(40);
    chk("R6 count", 32'(log_n), 32'd4);
    chk("R6 header first", 32'(log_q[0]), 32'h0A01);
    chk("R6 body kept", 32'(log_q[1]), 32'h4A02);
    chk("R6 tail kept", 32'(log_q[2]), 32'h8A03);
    chk("R6 other source after tail", 32'(log_q[3]), 32'hC0B0);
  endtask

  task automatic t_prio();
    do_reset();
    fmem[0][0] = 16'h0B01; fmem[0][1] = 16'h8B02; flen[0] = 2;
    fmem[1][0] = 16'hC0C1; flen[1] = 1;
    sink_on = 1'b1; feed_on[0] = 1'b1; feed_on[1] = 1'b1;
    wait_cycles(30);
    chk("R7 count", 32'(log_n), 32'd3);
    chk("R7 lowest source first", 32'(log_q[0]), 32'h0B01);
    chk("R7 packet completes", 32'(log_q[1]), 32'h8B02);
    chk("R7 higher source last", 32'(log_q[2]), 32'hC0C1);
  endtask

  task automatic t_orphan();
    do_reset();
    fmem[0][0] = 16'h4D01; fmem[0][1] = 16'h8D02; fmem[0][2] = 16'hC0D3; flen[0] = 3;
    sink_on = 1'b1; feed_on[0] = 1'b1;
    wait_cycles(30);
    chk("R8 two orphans flagged", 32'(errs), 32'd2);
    chk("R8 orphans dropped", 32'(log_n), 32'd1);
    chk("R8 link keeps working", 32'(log_q[0]), 32'hC0D3);
    chk("R1 no packet open after reset", 32'(fidx[0]), 32'd3);
  endtask

  task automatic t_solo();
    do_reset();
    fmem[1][0] = 16'hC0E1; fmem[1][1] = 16'h0E02; fmem[1][2] = 16'h8E03; flen[1] = 3;
    fmem[0][0] = 16'hC0E4; flen[0] = 1;
    sink_on = 1'b1; feed_on[1] = 1'b1;
    wait_taken(1, 1);
    feed_on[0] = 1'b1;
    wait_cycles(40);
    chk("R9 count", 32'(log_n), 32'd4);
    chk("R9 single first", 32'(log_q[0]), 32'hC0E1);
    chk("R9 other source wins next", 32'(log_q[1]), 32'hC0E4);
    chk("R9 header after", 32'(log_q[2]), 32'h0E02);
    chk("R9 tail last", 32'(log_q[3]), 32'h8E03);
    chk("R9 no errors", 32'(errs), 32'd0);
  endtask

  initial begin
    checks = 0;
    fails = 0;
    cyc = 0;
    rst_n = 1'b0;
    sink_on = 1'b0;
    out_taken = 1'b0;
    src_valid = '0;
    src_flit = '0;
    log_n = 0;
    errs = 0;
    for (int i = 0; i < NSRC; i++) begin
      feed_on[i] = 1'b0;
      acc_pend[i] = 1'b0;
      fidx[i] = 0;
      flen[i] = 0;
      for (int j = 0; j < 8; j++) fmem[i][j] = '0;
    end
    t_reset();
    t_timing();
    t_stream();
    t_lock();
    t_prio();
    t_orphan();
    t_solo();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule